// File: doc/BRIEF.md
# Disk interrupt request controller

This block drives the interrupt line that a parallel disk drive presents to its host. It keeps one pending-interrupt flag. The flag is set by an event from the drive core, or by the start of a data block during a programmed-I/O transfer. Certain host register accesses and either reset clear it. The interrupt pin itself is a registered copy of the pending flag. That copy is gated by two conditions: this drive must be the selected one, and the host must not have set the interrupt-disable bit.

The block sees raw host register strobes: read, write, the command-block and control-block chip selects, and a 3-bit register offset. It decodes only the two accesses that clear the flag. A built-in sequencer counts sectors against a block length. The host loads that length with the set-multiple command, and a value of 0 means one sector per block. The sequencer raises an interrupt at each block boundary. For write-type transfers it holds back the interrupt for the first block.

Top module: `dsk_irq_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `pend_o` and `irq_o` are 0 and the block length returns to one sector. Without a set event the pending flag never rises.
- R2: `irq_o` is a register. After each clock edge it equals (pending flag after that edge) AND `sel_i` AND NOT `dis_i`, where `sel_i` and `dis_i` are the values sampled at that edge.
- R3: Deselecting the drive or setting `dis_i` masks `irq_o` but leaves `pend_o` set. `irq_o` returns one clock after both conditions are true again.
- R4: A status read clears the pending flag. A status read is `rd_i` with `cs_cmd_i`=1, `cs_ctl_i`=0 and `ofs_i`=7. No other combination of chip selects, offset or strobe clears it. This includes the alternate status read (`cs_ctl_i`=1, `ofs_i`=6).
- R5: A command write clears the pending flag. A command write is `wr_i` with `cs_cmd_i`=1, `cs_ctl_i`=0 and `ofs_i`=7.
- R6: While `sw_rst_i` is high, the pending flag is cleared.
- R7: If a set event (`ev_pend_i` or a block boundary) arrives in the same cycle as any clear, the set wins and `pend_o` is 1 after the edge.
- R8: `xfer_start_i` begins a transfer and latches `cls_i` (0 read, 1 write-type, 2 non-data). Each `sec_go_i` pulse marks the start of a sector. Sector k, counting from 0, starts a block when k mod L = 0. L is the loaded length, or 1 if the loaded length is 0.
- R9: A block start sets the pending flag, one clock later, like a drive event.
- R10: For class 1 (write-type), the block start at sector 0 does not set the flag. Later block starts of the same transfer do set it.
- R11: If `xfer_start_i` and `sec_go_i` arrive in the same cycle, that sector is sector 0 of the new transfer, with the new class.
- R12: `mult_we_i` loads `mult_val_i` as the block length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| ev_pend_i | input | 1 | Interrupt event from drive core |
| sel_i | input | 1 | This drive is currently selected |
| dis_i | input | 1 | Interrupt-disable bit of device control |
| sw_rst_i | input | 1 | Software reset bit of device control |
| rd_i | input | 1 | Host register read strobe |
| wr_i | input | 1 | Host register write strobe |
| cs_cmd_i | input | 1 | Command-block chip select |
| cs_ctl_i | input | 1 | Control-block chip select |
| ofs_i | input | 3 | Register offset |
| mult_we_i | input | 1 | Load block length |
| mult_val_i | input | CNT_W | Block length in sectors |
| xfer_start_i | input | 1 | Start of a data transfer |
| cls_i | input | 2 | Command class of the transfer |
| sec_go_i | input | 1 | A sector is about to transfer |
| pend_o | output | 1 | Pending interrupt flag |
| irq_o | output | 1 | Interrupt request to host |

## Verification
Every result of this block is due exactly one clock after its cause. This holds for setting or clearing the pending flag, for gating the pin, and for block-boundary events. The bench drives each stimulus just after a falling edge and samples both outputs at the next falling edge. That moment is after the single rising edge that registers the effect and before any later edge. After each block-boundary check, a status read returns the flag to 0, so every sector of the sweep is judged on its own.

// File: rtl/dsk_irq_pkg.sv
package dsk_irq_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_CMDSTAT = 3'd7;

  typedef enum logic [1:0] {
    XC_READ   = 2'd0,
    XC_WRITE  = 2'd1,
    XC_NODATA = 2'd2,
    XC_RSVD   = 2'd3
  } xfer_cls_e;

  function automatic logic first_block_quiet(xfer_cls_e c);
    return c == XC_WRITE;
  endfunction
endpackage

// File: rtl/dsk_irq_regdec.sv
module dsk_irq_regdec
  import dsk_irq_pkg::*;
(
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             cs_cmd_i,
  input  logic             cs_ctl_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             stat_rd_o,
  output logic             cmd_wr_o
);
  logic hit;

  always_comb begin
    // command-block only; both selects at once is not a valid access
    hit       = cs_cmd_i && !cs_ctl_i && (ofs_i == OFS_CMDSTAT);
    stat_rd_o = hit && rd_i;
    cmd_wr_o  = hit && wr_i;
  end
endmodule

// File: rtl/dsk_irq_blkseq.sv
module dsk_irq_blkseq
  import dsk_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mult_we_i,
  input  logic [CNT_W-1:0] mult_val_i,
  input  logic             xfer_start_i,
  input  logic [1:0]       cls_i,
  input  logic             sec_go_i,
  output logic             blk_ev_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] mult_q, blk_len, pos_q, pos_eff;
  logic [CNT_W:0]   pos_inc;
  logic             first_q, first_eff, boundary;
  xfer_cls_e        cls_q, cls_eff;

  always_comb begin
    blk_len   = (mult_q == '0) ? ONE : mult_q;
    pos_eff   = xfer_start_i ? '0 : pos_q;
    first_eff = xfer_start_i ? 1'b1 : first_q;
    cls_eff   = xfer_start_i ? xfer_cls_e'(cls_i) : cls_q;
    pos_inc   = {1'b0, pos_eff} + {{CNT_W{1'b0}}, 1'b1};
    boundary  = sec_go_i && (pos_eff == '0);
    blk_ev_o  = boundary && !(first_eff && first_block_quiet(cls_eff));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q  <= ONE;
      pos_q   <= '0;
      first_q <= 1'b1;
      cls_q   <= XC_READ;
    end else begin
      if (mult_we_i) mult_q <= mult_val_i;
      cls_q <= cls_eff;
      if (sec_go_i) begin
        pos_q   <= (pos_inc >= {1'b0, blk_len}) ? '0 : pos_inc[CNT_W-1:0];
        first_q <= first_eff && !boundary;
      end else begin
        pos_q   <= pos_eff;
        first_q <= first_eff;
      end
    end
  end
endmodule

// File: rtl/dsk_irq_pend.sv
module dsk_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic sel_i,
  input  logic dis_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_nxt;

  always_comb begin
    if (set_i)      pend_nxt = 1'b1;
    else if (clr_i) pend_nxt = 1'b0;
    else            pend_nxt = pend_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_nxt;
      irq_o  <= pend_nxt && sel_i && !dis_i;
    end
  end
endmodule

// File: rtl/dsk_irq_top.sv
module dsk_irq_top
  import dsk_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_pend_i,
  input  logic             sel_i,
  input  logic             dis_i,
  input  logic             sw_rst_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             cs_cmd_i,
  input  logic             cs_ctl_i,
  input  logic [2:0]       ofs_i,
  input  logic             mult_we_i,
  input  logic [CNT_W-1:0] mult_val_i,
  input  logic             xfer_start_i,
  input  logic [1:0]       cls_i,
  input  logic             sec_go_i,
  output logic             pend_o,
  output logic             irq_o
);
  logic stat_rd, cmd_wr, blk_ev, set_any, clr_any;

  dsk_irq_regdec u_dec (
    .rd_i(rd_i), .wr_i(wr_i), .cs_cmd_i(cs_cmd_i), .cs_ctl_i(cs_ctl_i),
    .ofs_i(ofs_i), .stat_rd_o(stat_rd), .cmd_wr_o(cmd_wr)
  );

  dsk_irq_blkseq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .mult_we_i(mult_we_i), .mult_val_i(mult_val_i),
    .xfer_start_i(xfer_start_i), .cls_i(cls_i), .sec_go_i(sec_go_i),
    .blk_ev_o(blk_ev)
  );

  always_comb begin
    set_any = ev_pend_i || blk_ev;
    clr_any = sw_rst_i || stat_rd || cmd_wr;
  end

  dsk_irq_pend u_pend (
    .clk(clk), .rst(rst), .set_i(set_any), .clr_i(clr_any),
    .sel_i(sel_i), .dis_i(dis_i), .pend_o(pend_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/dsk_irq_chk.sv
module dsk_irq_chk (
  input logic clk,
  input logic rst,
  input logic ev_pend_i,
  input logic blk_ev,
  input logic stat_rd,
  input logic cmd_wr,
  input logic sw_rst_i,
  input logic sel_i,
  input logic dis_i,
  input logic pend_o,
  input logic irq_o
);
  a_r2_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend_o && $past(sel_i) && !$past(dis_i)));
  a_r3_irq_returns: assert property (@(posedge clk) disable iff (rst)
    (pend_o && $past(sel_i) && !$past(dis_i)) |-> irq_o);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ev_pend_i || blk_ev) |=> pend_o);
  a_r4_stat_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ev_pend_i && !blk_ev) |=> !pend_o);
  a_r5_cmd_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !ev_pend_i && !blk_ev) |=> !pend_o);
  a_r6_sw_clears: assert property (@(posedge clk) disable iff (rst)
    (sw_rst_i && !ev_pend_i && !blk_ev) |=> !pend_o);
  a_r3_pend_held: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !stat_rd && !cmd_wr && !sw_rst_i) |=> pend_o);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && !ev_pend_i && !blk_ev) |=> !pend_o);
endmodule

bind dsk_irq_top dsk_irq_chk u_chk (
  .clk(clk), .rst(rst), .ev_pend_i(ev_pend_i), .blk_ev(blk_ev),
  .stat_rd(stat_rd), .cmd_wr(cmd_wr), .sw_rst_i(sw_rst_i),
  .sel_i(sel_i), .dis_i(dis_i), .pend_o(pend_o), .irq_o(irq_o)
);

// File: tb/tb_dsk_irq_top.sv
`timescale 1ns/1ps
module tb_dsk_irq_top;
  localparam int CNT_W = 8;
  localparam int WD_CYC = 50000;

  logic clk = 1'b0;
  logic rst, ev_pend_i, sel_i, dis_i, sw_rst_i, rd_i, wr_i, cs_cmd_i, cs_ctl_i;
  logic [2:0] ofs_i;
  logic mult_we_i, xfer_start_i, sec_go_i, pend_o, irq_o;
  logic [CNT_W-1:0] mult_val_i;
  logic [1:0] cls_i;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  dsk_irq_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .ev_pend_i(ev_pend_i), .sel_i(sel_i), .dis_i(dis_i),
    .sw_rst_i(sw_rst_i), .rd_i(rd_i), .wr_i(wr_i), .cs_cmd_i(cs_cmd_i),
    .cs_ctl_i(cs_ctl_i), .ofs_i(ofs_i), .mult_we_i(mult_we_i),
    .mult_val_i(mult_val_i), .xfer_start_i(xfer_start_i), .cls_i(cls_i),
    .sec_go_i(sec_go_i), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_pend_i = 0; sw_rst_i = 0; rd_i = 0; wr_i = 0; cs_cmd_i = 0; cs_ctl_i = 0;
    ofs_i = 0; mult_we_i = 0; xfer_start_i = 0; sec_go_i = 0;
  endtask

  // one clock: inputs already driven; returns at next falling edge, pulses cleared
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic stat_read();
    rd_i = 1; cs_cmd_i = 1; ofs_i = 3'd7; step();
  endtask

  task automatic raise();
    ev_pend_i = 1; step();
  endtask

  task automatic final_report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    final_report();
  end

  initial begin
    idle(); rst = 1; sel_i = 1; dis_i = 0; cls_i = 0; mult_val_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pend", pend_o, 1'b0);
    chk("R1 reset irq", irq_o, 1'b0);
    rst = 0; step();
    step(); step();
    chk("R1 idle stays clear", pend_o, 1'b0);

    // R2: exhaustive select / disable gating
    for (int m = 0; m < 4; m++) begin
      sel_i = m[0]; dis_i = m[1];
      raise();
      chk("R2 pend after event", pend_o, 1'b1);
      chk("R2 irq gating", irq_o, m[0] && !m[1]);
      stat_read();
      chk("R4 cleared", pend_o, 1'b0);
      chk("R2 irq drops", irq_o, 1'b0);
    end

    // R3: masking keeps pending, output returns
    sel_i = 1; dis_i = 0; raise();
    sel_i = 0; step();
    chk("R3 desel masks", irq_o, 1'b0);
    chk("R3 pend kept", pend_o, 1'b1);
    sel_i = 1; dis_i = 1; step();
    chk("R3 disable masks", irq_o, 1'b0);
    dis_i = 0; step();
    chk("R3 irq back", irq_o, 1'b1);
    chk("R3 pend still", pend_o, 1'b1);
    stat_read();

    // R4/R5: exhaustive decode sweep of strobes, selects and offsets
    for (int v = 0; v < 128; v++) begin
      raise();
      rd_i = v[0]; wr_i = v[1]; cs_cmd_i = v[2]; cs_ctl_i = v[3]; ofs_i = v[6:4];
      step();
      chk("R4 R5 decode", pend_o,
          !(v[2] && !v[3] && v[6:4] == 3'd7 && (v[0] || v[1])));
      stat_read();
    end

    // R6 software reset, R7 set wins over each clear
    raise(); sw_rst_i = 1; step();
    chk("R6 sw reset clears", pend_o, 1'b0);
    for (int c = 0; c < 3; c++) begin
      raise();
      ev_pend_i = 1;
      if (c == 0) sw_rst_i = 1;
      else begin cs_cmd_i = 1; ofs_i = 3'd7; rd_i = (c == 1); wr_i = (c == 2); end
      step();
      chk("R7 set wins", pend_o, 1'b1);
      chk("R7 irq set", irq_o, 1'b1);
      stat_read();
    end

    // R8-R10, R12: block sweep over length and class
    for (int n = 0; n < 5; n++) begin
      for (int cl = 0; cl < 3; cl++) begin
        mult_we_i = 1; mult_val_i = CNT_W'(n); step();
        xfer_start_i = 1; cls_i = 2'(cl); step();
        for (int k = 0; k < 9; k++) begin
          automatic int len = (n == 0) ? 1 : n;
          automatic logic exp = (k % len == 0) && !(cl == 1 && k == 0);
          sec_go_i = 1; step();
          chk("R8 R9 R10 R12 block irq", pend_o, exp);
          chk("R9 block pin", irq_o, exp);
          stat_read();
        end
      end
    end

    // R11: start and first sector in the same cycle, write class
    mult_we_i = 1; mult_val_i = 8'd2; step();
    xfer_start_i = 1; cls_i = 2'd0; step();
    sec_go_i = 1; step(); stat_read();
    xfer_start_i = 1; cls_i = 2'd1; sec_go_i = 1; step();
    chk("R11 same-cycle start suppressed", pend_o, 1'b0);
    sec_go_i = 1; step();
    chk("R11 mid block quiet", pend_o, 1'b0);
    sec_go_i = 1; step();
    chk("R11 second block raises", pend_o, 1'b1);
    stat_read();

    // R1: hardware reset clears and restores block length 1
    raise(); rst = 1; step();
    chk("R1 hw reset pend", pend_o, 1'b0);
    chk("R1 hw reset irq", irq_o, 1'b0);
    rst = 0; step();
    for (int k = 0; k < 3; k++) begin
      sec_go_i = 1; step();
      chk("R1 length back to one", pend_o, 1'b1);
      stat_read();
    end

    final_report();
  end
endmodule